// File: doc/BRIEF.md
# MAC Control Register Block

This block is the register slave that sits in front of an Ethernet MAC's transmit and receive engines. A word-indexed read/write bus reaches a set of registers. The control word switches each engine on and off. Two list base addresses point the DMA engines at their descriptor rings. A set of parameter words covers the FIFO threshold, the longest receive frame, the missed-frame count and the management address. An interrupt enable mask and an interrupt status word complete the set. The DMA engines report events as single-cycle pulses on `evt_set`. Each pulse latches into the status word, and software clears status bits by writing ones to them.

The status word has two halves. Bits [15:0] hold receive events and bits [31:16] hold transmit events. Each half, masked by the matching half of the enable word, drives its own interrupt line.

Setting bit 24 of the control word starts a soft reset that runs for a fixed number of cycles. While it runs, every read returns zero, writes are ignored and all engine enables are held off. When it finishes, every register is back at its power-up value. This includes the address-match settings, so frame matching is disabled afterwards.

Top module: `macreg_top`

## Requirements
- R1: After hardware reset the registers read as follows. Index 3 (transmit list base) and index 4 (receive list base) read 0xFFFFFFFC. Index 7 (FIFO threshold) reads 0x00000101. Index 8 (maximum receive length) reads 0x00000800. Index 9 (missed-frame count) reads 0x00007FFF. Index 10 (management address) reads 0x00900000. Index 0 (control), 1 (match config), 2 (match enable), 5 (interrupt enable), 6 (interrupt status) and 11 (management data) read 0.
- R2: A write to index 0 with bit 24 set starts a soft reset lasting SRST_CYCLES (default 16) clock cycles. Every read sampled during that window returns 0. After it, every register reads its R1 value, and bit 24 of index 0 reads 0.
- R3: Bus writes that arrive while a soft reset is running are ignored.
- R4: `tx_en`, `rx_en` and `match_en` are 0 from the soft-reset write until the soft reset ends. Afterwards `match_cfg` and `match_en` are 0, and both list base outputs are 0xFFFFFFFC.
- R5: Indices 1, 2, 5, 7, 8, 9, 10 and 11 read back the last value written. Indices 3 and 4 read back the written value with bits [1:0] forced to 0.
- R6: Indices 12 to 15 read 0, and writes to them change nothing.
- R7: A 1 on `evt_set[b]` sets status bit b (index 6). Writing 1 to a status bit clears it, and writing 0 leaves it unchanged. An event in the same cycle as a clear leaves the bit set. Writing 0xFFFF0000 clears only the transmit half.
- R8: `irq_rx` rises one cycle after any status bit in [15:0] is set while its enable bit (index 5, same position) is 1. `irq_tx` does the same for bits [31:16]. Each line falls one cycle after its last enabled bit is cleared.
- R9: Bit 0 of index 0 drives `rx_en` and bit 8 drives `tx_en`. Both take effect on the clock edge that performs the write.
- R10: `bus_rdata` is loaded on the clock edge that samples `bus_rd` high, and holds its value until the next read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_wr | input | 1 | Write strobe |
| bus_rd | input | 1 | Read strobe |
| bus_addr | input | AW | Word index |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Registered read data |
| evt_set | input | 32 | Event pulses from the DMA engines, one per status bit |
| tx_en | output | 1 | Transmit engine enable |
| rx_en | output | 1 | Receive engine enable |
| tx_list_base | output | 32 | Transmit descriptor list base |
| rx_list_base | output | 32 | Receive descriptor list base |
| match_cfg | output | 32 | Address-match configuration |
| match_en | output | 32 | Address-match entry enables |
| irq_rx | output | 1 | Receive interrupt |
| irq_tx | output | 1 | Transmit interrupt |

## Verification
The bench counts the zero reads that follow a soft-reset write. A sequencer that is one cycle short or long, or that lets a live register leak onto the bus, changes that count from exactly sixteen. It writes during a soft reset and writes to unmapped indices, then reads back. It also sweeps all 32 status bits one at a time. This catches a swapped interrupt half, an enable applied to the wrong bit, or a clear that wipes the whole word instead of the written mask. It also drives an event in the same cycle as its clear, which exposes a design that lets the clear win and loses the event.

// File: rtl/macreg_pkg.sv
package macreg_pkg;
  localparam int unsigned WORD_W   = 32;
  localparam int unsigned NUM_REGS = 12;
  localparam int unsigned HALF_W   = WORD_W / 2;

  localparam int IDX_CTRL      = 0;
  localparam int IDX_MATCH_CFG = 1;
  localparam int IDX_MATCH_EN  = 2;
  localparam int IDX_TX_BASE   = 3;
  localparam int IDX_RX_BASE   = 4;
  localparam int IDX_INT_EN    = 5;
  localparam int IDX_INT_STAT  = 6;
  localparam int IDX_FIFO_THR  = 7;
  localparam int IDX_RX_MAXLEN = 8;
  localparam int IDX_MISS_CNT  = 9;
  localparam int IDX_MGMT_ADDR = 10;
  localparam int IDX_MGMT_DATA = 11;

  localparam int CTRL_RX_BIT   = 0;
  localparam int CTRL_TX_BIT   = 8;
  localparam int CTRL_SRST_BIT = 24;

  function automatic logic [WORD_W-1:0] reg_reset(input int idx);
    case (idx)
      IDX_TX_BASE, IDX_RX_BASE: return 32'hFFFF_FFFC;
      IDX_FIFO_THR:             return 32'h0000_0101;
      IDX_RX_MAXLEN:            return 32'h0000_0800;
      IDX_MISS_CNT:             return 32'h0000_7FFF;
      IDX_MGMT_ADDR:            return 32'h0090_0000;
      default:                  return '0;
    endcase
  endfunction

  function automatic logic [WORD_W-1:0] reg_wmask(input int idx);
    case (idx)
      IDX_TX_BASE, IDX_RX_BASE: return 32'hFFFF_FFFC;
      IDX_CTRL:                 return ~(32'd1 << CTRL_SRST_BIT);
      default:                  return '1;
    endcase
  endfunction
endpackage

// File: rtl/macreg_srst.sv
module macreg_srst #(
  parameter int SRST_CYCLES = 16
) (
  input  logic clk,
  input  logic rst,
  input  logic start,
  output logic busy
);
  localparam int CW = $clog2(SRST_CYCLES + 1);
  localparam logic [CW-1:0] LAST = CW'(SRST_CYCLES - 1);

  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      busy  <= 1'b0;
      cnt_q <= '0;
    end else if (busy) begin
      if (cnt_q == LAST) begin
        busy  <= 1'b0;
        cnt_q <= '0;
      end else begin
        cnt_q <= cnt_q + 1'b1;
      end
    end else if (start) begin
      busy  <= 1'b1;
      cnt_q <= '0;
    end
  end
endmodule

// File: rtl/macreg_stat.sv
module macreg_stat
  import macreg_pkg::*;
(
  input  logic              clk,
  input  logic              clr,
  input  logic [WORD_W-1:0] evt_set,
  input  logic              w1c_we,
  input  logic [WORD_W-1:0] w1c_mask,
  input  logic [WORD_W-1:0] int_en,
  output logic [WORD_W-1:0] stat_q,
  output logic              irq_rx,
  output logic              irq_tx
);
  logic [1:0] irq_q;

  always_ff @(posedge clk) begin
    if (clr) stat_q <= '0;
    else     stat_q <= (stat_q & ~(w1c_we ? w1c_mask : '0)) | evt_set;
  end

  // half 0 = receive events, half 1 = transmit events
  for (genvar h = 0; h < 2; h++) begin : g_half
    always_ff @(posedge clk) begin
      if (clr) irq_q[h] <= 1'b0;
      else     irq_q[h] <= |(stat_q[h*HALF_W +: HALF_W] & int_en[h*HALF_W +: HALF_W]);
    end
  end

  assign irq_rx = irq_q[0];
  assign irq_tx = irq_q[1];
endmodule

// File: rtl/macreg_top.sv
module macreg_top
  import macreg_pkg::*;
#(
  parameter int AW          = 4,
  parameter int SRST_CYCLES = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              bus_wr,
  input  logic              bus_rd,
  input  logic [AW-1:0]     bus_addr,
  input  logic [WORD_W-1:0] bus_wdata,
  output logic [WORD_W-1:0] bus_rdata,
  input  logic [WORD_W-1:0] evt_set,
  output logic              tx_en,
  output logic              rx_en,
  output logic [WORD_W-1:0] tx_list_base,
  output logic [WORD_W-1:0] rx_list_base,
  output logic [WORD_W-1:0] match_cfg,
  output logic [WORD_W-1:0] match_en,
  output logic              irq_rx,
  output logic              irq_tx
);
  logic              srst_busy;
  logic              wr_ok;
  logic              srst_go;
  logic              soft_clr;
  logic [WORD_W-1:0] regs_q [NUM_REGS];
  logic [WORD_W-1:0] stat_q;
  logic [WORD_W-1:0] int_en_q;
  logic [WORD_W-1:0] rd_val;

  assign wr_ok    = bus_wr && !srst_busy;
  assign srst_go  = wr_ok && (bus_addr == AW'(IDX_CTRL)) && bus_wdata[CTRL_SRST_BIT];
  assign soft_clr = rst || srst_busy || srst_go;

  macreg_srst #(.SRST_CYCLES(SRST_CYCLES)) u_srst (
    .clk   (clk),
    .rst   (rst),
    .start (srst_go),
    .busy  (srst_busy)
  );

  for (genvar g = 0; g < NUM_REGS; g++) begin : g_reg
    if (g == IDX_INT_STAT) begin : g_stat_slot
      assign regs_q[g] = stat_q;
    end else begin : g_rw
      localparam logic [WORD_W-1:0] RV = reg_reset(g);
      localparam logic [WORD_W-1:0] WM = reg_wmask(g);
      always_ff @(posedge clk) begin
        if (soft_clr)                            regs_q[g] <= RV;
        else if (wr_ok && bus_addr == AW'(g))    regs_q[g] <= bus_wdata & WM;
      end
    end
  end

  assign int_en_q = regs_q[IDX_INT_EN];

  macreg_stat u_stat (
    .clk      (clk),
    .clr      (soft_clr),
    .evt_set  (evt_set),
    .w1c_we   (wr_ok && bus_addr == AW'(IDX_INT_STAT)),
    .w1c_mask (bus_wdata),
    .int_en   (int_en_q),
    .stat_q   (stat_q),
    .irq_rx   (irq_rx),
    .irq_tx   (irq_tx)
  );

  always_comb begin
    rd_val = '0;
    for (int i = 0; i < NUM_REGS; i++)
      if (bus_addr == AW'(i)) rd_val = regs_q[i];
  end

  always_ff @(posedge clk) begin
    if (rst)         bus_rdata <= '0;
    else if (bus_rd) bus_rdata <= srst_busy ? '0 : rd_val;
  end

  assign rx_en        = regs_q[IDX_CTRL][CTRL_RX_BIT];
  assign tx_en        = regs_q[IDX_CTRL][CTRL_TX_BIT];
  assign tx_list_base = regs_q[IDX_TX_BASE];
  assign rx_list_base = regs_q[IDX_RX_BASE];
  assign match_cfg    = regs_q[IDX_MATCH_CFG];
  assign match_en     = regs_q[IDX_MATCH_EN];
endmodule

// File: rtl/macreg_chk.sv
module macreg_chk
  import macreg_pkg::*;
#(
  parameter int AW          = 4,
  parameter int SRST_CYCLES = 16
) (
  input logic              clk,
  input logic              rst,
  input logic              busy,
  input logic              bus_wr,
  input logic              bus_rd,
  input logic [AW-1:0]     bus_addr,
  input logic [WORD_W-1:0] bus_wdata,
  input logic [WORD_W-1:0] bus_rdata,
  input logic [WORD_W-1:0] evt_set,
  input logic [WORD_W-1:0] stat_q,
  input logic [WORD_W-1:0] int_en,
  input logic              tx_en,
  input logic              rx_en,
  input logic [WORD_W-1:0] match_en,
  input logic              irq_rx,
  input logic              irq_tx
);
  int run_len;
  always_ff @(posedge clk) begin
    if (rst)       run_len <= 0;
    else if (busy) run_len <= run_len + 1;
    else           run_len <= 0;
  end

  AST_RD_ZERO_IN_SRST: assert property (@(posedge clk) disable iff (rst)
    busy && bus_rd |=> bus_rdata == '0);  // R2
  AST_SRST_LENGTH: assert property (@(posedge clk) disable iff (rst)
    $fell(busy) |-> run_len == SRST_CYCLES);  // R2
  AST_STAT_EMPTY_IN_SRST: assert property (@(posedge clk) disable iff (rst)
    busy |=> stat_q == '0);  // R2
  AST_EN_OFF_IN_SRST: assert property (@(posedge clk) disable iff (rst)
    busy |-> !tx_en && !rx_en && match_en == '0);  // R4
  AST_W1C_CLEARS: assert property (@(posedge clk) disable iff (rst)
    bus_wr && !busy && bus_addr == AW'(IDX_INT_STAT) && evt_set == '0
      |=> (stat_q & $past(bus_wdata)) == '0);  // R7
  AST_IRQ_TX_NEEDS_EN: assert property (@(posedge clk) disable iff (rst)
    irq_tx |-> $past(int_en[WORD_W-1:HALF_W]) != '0);  // R8
  AST_IRQ_RX_NEEDS_EN: assert property (@(posedge clk) disable iff (rst)
    irq_rx |-> $past(int_en[HALF_W-1:0]) != '0);  // R8
endmodule

bind macreg_top macreg_chk #(.AW(AW), .SRST_CYCLES(SRST_CYCLES)) u_chk (
  .clk       (clk),
  .rst       (rst),
  .busy      (srst_busy),
  .bus_wr    (bus_wr),
  .bus_rd    (bus_rd),
  .bus_addr  (bus_addr),
  .bus_wdata (bus_wdata),
  .bus_rdata (bus_rdata),
  .evt_set   (evt_set),
  .stat_q    (stat_q),
  .int_en    (int_en_q),
  .tx_en     (tx_en),
  .rx_en     (rx_en),
  .match_en  (match_en),
  .irq_rx    (irq_rx),
  .irq_tx    (irq_tx)
);

// File: tb/sim_macreg_top.sv
`timescale 1ns/1ps
module sim_macreg_top;
  localparam int AW = 4;
  localparam int NW = 1 << AW;
  localparam int SRST_N = 16;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        bus_wr = 1'b0;
  logic        bus_rd = 1'b0;
  logic [AW-1:0] bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic [31:0] evt_set = '0;
  logic        tx_en, rx_en, irq_rx, irq_tx;
  logic [31:0] tx_list_base, rx_list_base, match_cfg, match_en;

  int checks = 0;
  int errors = 0;

  always #10 clk = ~clk;

  macreg_top #(.AW(AW), .SRST_CYCLES(SRST_N)) u0 (
    .clk(clk), .rst(rst), .bus_wr(bus_wr), .bus_rd(bus_rd), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .evt_set(evt_set),
    .tx_en(tx_en), .rx_en(rx_en), .tx_list_base(tx_list_base),
    .rx_list_base(rx_list_base), .match_cfg(match_cfg), .match_en(match_en),
    .irq_rx(irq_rx), .irq_tx(irq_tx)
  );

  function automatic logic [31:0] exp_reset(input int i);
    case (i)
      3, 4:    return 32'hFFFF_FFFC;
      7:       return 32'h0000_0101;
      8:       return 32'h0000_0800;
      9:       return 32'h0000_7FFF;
      10:      return 32'h0090_0000;
      default: return 32'h0;
    endcase
  endfunction

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input int a, input logic [31:0] d);
    bus_wr = 1'b1; bus_addr = AW'(a); bus_wdata = d;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic rd(input int a, output logic [31:0] d);
    bus_rd = 1'b1; bus_addr = AW'(a);
    @(negedge clk);
    bus_rd = 1'b0;
    d = bus_rdata;
  endtask

  task automatic soft_reset_and_wait();
    wr(0, 32'h0100_0000);
    repeat (SRST_N + 2) @(negedge clk);
  endtask

  initial begin
    #(20 * 150000);
    errors++;
    $display("FAIL watchdog expired");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    logic [31:0] v;
    int zeros;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);

    // R1 reset values over every index
    for (int i = 0; i < NW; i++) begin
      rd(i, v);
      chk($sformatf("R1 idx %0d", i), v, exp_reset(i));
    end
    chk("R1 irq lines", {30'd0, irq_tx, irq_rx}, 32'd0);

    // R5 read/write sweep
    for (int i = 1; i < 12; i++) begin
      if (i == 6) continue;
      wr(i, 32'hA5C3_0F0F + 32'(i));
      rd(i, v);
      chk($sformatf("R5 idx %0d", i), v,
          (i == 3 || i == 4) ? ((32'hA5C3_0F0F + 32'(i)) & 32'hFFFF_FFFC)
                             : (32'hA5C3_0F0F + 32'(i)));
    end
    // R10 data holds without a read strobe
    repeat (3) @(negedge clk);
    chk("R10 hold", bus_rdata, 32'hA5C3_0F1A);

    // R6 unmapped indices
    for (int i = 12; i < NW; i++) begin
      wr(i, 32'hFFFF_FFFF);
      rd(i, v);
      chk($sformatf("R6 idx %0d", i), v, 32'h0);
    end
    rd(7, v);
    chk("R6 mapped untouched", v, 32'hA5C3_0F16);

    // R9 control enables
    wr(0, 32'h0000_0101);
    chk("R9 tx_en", {31'd0, tx_en}, 32'd1);
    chk("R9 rx_en", {31'd0, rx_en}, 32'd1);
    wr(0, 32'h0000_0100);
    chk("R9 rx_en off", {31'd0, rx_en}, 32'd0);
    wr(0, 32'h0000_0101);

    // R4 / R2 soft reset
    wr(2, 32'h0000_0001);
    wr(0, 32'h0100_0101);
    chk("R4 tx_en off", {31'd0, tx_en}, 32'd0);
    chk("R4 rx_en off", {31'd0, rx_en}, 32'd0);
    chk("R4 match_en off", match_en, 32'd0);
    zeros = 0;
    for (int k = 0; k < 40; k++) begin
      rd(7, v);
      if (v != 0) break;
      zeros++;
    end
    chk("R2 zero reads during soft reset", 32'(zeros), 32'(SRST_N));
    chk("R2 value after soft reset", v, 32'h0000_0101);
    for (int i = 0; i < NW; i++) begin
      rd(i, v);
      chk($sformatf("R2 idx %0d after soft reset", i), v, exp_reset(i));
    end
    chk("R4 tx base", tx_list_base, 32'hFFFF_FFFC);
    chk("R4 rx base", rx_list_base, 32'hFFFF_FFFC);
    chk("R4 match_cfg", match_cfg, 32'h0);

    // R3 writes during soft reset ignored
    wr(0, 32'h0100_0000);
    wr(7, 32'h0000_0055);
    wr(0, 32'h0000_0101);
    wr(5, 32'hFFFF_FFFF);
    repeat (SRST_N + 2) @(negedge clk);
    rd(7, v);
    chk("R3 threshold", v, 32'h0000_0101);
    rd(5, v);
    chk("R3 int enable", v, 32'h0);
    chk("R3 tx_en", {31'd0, tx_en}, 32'd0);

    // R7 / R8 sweep of all status bits
    for (int b = 0; b < 32; b++) begin
      wr(5, 32'd1 << b);
      evt_set = 32'd1 << b;
      @(negedge clk);
      evt_set = '0;
      chk($sformatf("R8 irq not yet bit %0d", b), {30'd0, irq_tx, irq_rx}, 32'd0);
      @(negedge clk);
      chk($sformatf("R8 irq bit %0d", b), {30'd0, irq_tx, irq_rx},
          (b >= 16) ? 32'd2 : 32'd1);
      rd(6, v);
      chk($sformatf("R7 status bit %0d", b), v, 32'd1 << b);
      wr(6, 32'd1 << b);
      @(negedge clk);
      chk($sformatf("R8 irq drop bit %0d", b), {30'd0, irq_tx, irq_rx}, 32'd0);
      rd(6, v);
      chk($sformatf("R7 cleared bit %0d", b), v, 32'd0);
    end

    // R8 disabled events do not interrupt; R7 half clear
    wr(5, 32'h0000_0000);
    evt_set = 32'hFFFF_FFFF;
    @(negedge clk);
    evt_set = '0;
    repeat (2) @(negedge clk);
    chk("R8 masked", {30'd0, irq_tx, irq_rx}, 32'd0);
    wr(6, 32'hFFFF_0000);
    rd(6, v);
    chk("R7 transmit half clear", v, 32'h0000_FFFF);
    wr(6, 32'h0000_0001);
    rd(6, v);
    chk("R7 write zero keeps", v, 32'h0000_FFFE);
    wr(6, 32'hFFFF_FFFF);

    // R7 event beats clear in same cycle
    evt_set = 32'h0000_0008;
    wr(6, 32'h0000_0008);
    evt_set = '0;
    rd(6, v);
    chk("R7 event wins", v, 32'h0000_0008);

    // R8 enabling after status is set raises the line
    wr(5, 32'h0000_0008);
    @(negedge clk);
    chk("R8 late enable", {30'd0, irq_tx, irq_rx}, 32'd1);
    soft_reset_and_wait();
    chk("R2 irq cleared by soft reset", {30'd0, irq_tx, irq_rx}, 32'd0);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule